// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software running on the bus clock. Once enabled, a 32-bit counter is loaded with a period taken from one of sixteen power-of-two ranges and counts down on every clock. Software has to write a restart key before the count reaches zero. If it does not, the block responds in one of two ways. In direct mode it issues a system reset pulse at once. In interrupt-first mode it first raises an interrupt, and it issues the reset only if that interrupt is still pending when the next period expires.

The register interface is write-only and uses an 8-bit data word. There are four addresses: control (enable, response mode, pulse length), range, restart key and interrupt acknowledge. The reset output is a pulse whose length is set by a 3-bit field. Once the enable bit has been set, only the block's reset input can clear it.

Top module: `wdog_twostage`

## Requirements
- R1: When enabled, the counter is loaded with 2^(BASE_EXP+i)-1, where i is the range index held in bits [3:0] of the range register (address 1). It decrements every clock, so a timeout occurs exactly 2^(BASE_EXP+i) clocks after each load. The enabling write is itself a load.
- R2: In direct mode (control bit 1 = 0), a timeout drives `sysRst` high from the next clock and reloads the counter.
- R3: In interrupt-first mode (control bit 1 = 1), the first timeout sets `irq`. A timeout that finds `irq` still set issues the reset pulse and clears `irq`.
- R4: A write to the acknowledge register (address 3, any data) clears `irq`. After an acknowledge, the next timeout raises `irq` again instead of resetting.
- R5: Writing 0x76 in data bits [7:0] to the restart register (address 2) reloads the counter and clears `irq`. A restart wins over a timeout in the same clock.
- R6: Any other value written to the restart register has no effect on the timeout schedule.
- R7: The reset pulse lasts 2^(L+1) clocks, where L is control bits [4:2] (2 to 256 clocks). A timeout during an active pulse restarts the pulse.
- R8: Control bit 0 enables the counter. Writing 0 to it afterwards does not stop the watchdog; only `rstN` clears it.
- R9: After `rstN`, `irq` and `sysRst` are low and the block is disabled. While disabled, no timeout occurs, whatever is written to the restart register.
- R10: A range write takes effect at the next counter load (restart, timeout or enable), not mid-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 control, 1 range, 2 restart, 3 acknowledge |
| wrData | input | 8 | Write data |
| irq | output | 1 | Interrupt, high while a first-stage timeout is pending |
| sysRst | output | 1 | System reset pulse, active high |

## Verification
Every register write takes effect at the clock edge that samples it. `irq` and `sysRst` change at the edge that sees the counter at zero, which is 2^(BASE_EXP+i) edges after the enabling or restart write. An acknowledge or restart shows on `irq` one edge after the write. The bench keeps a behavioural model that advances on each rising edge from the same sampled inputs, and compares both outputs with it at every falling edge. Targeted checks count falling edges from a write, and measure pulse widths in whole clocks of `sysRst` high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_RANGE = 2'd1,
    ADDR_KICK  = 2'd2,
    ADDR_ACK   = 2'd3
  } regAddr_t;

  localparam logic [7:0] KICK_KEY = 8'h76;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic reload;
    logic decr;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16,
  parameter int RANGE_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         stb,
  input  logic [RANGE_W-1:0] rangeSel,
  output logic               cntZero
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] preset;
  logic [7:0]       shAmt;

  always_comb begin
    shAmt  = 8'(BASE_EXP) + 8'(rangeSel);
    preset = (CNT_W'(1) << shAmt) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (stb.reload) cnt <= preset;
    else if (stb.decr)   cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RANGE_W = 4,
  parameter int LEN_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  logic               cntZero,
  output cntStrobe_t         stb,
  output logic [RANGE_W-1:0] rangeSel,
  output logic               enabled,
  output logic               modeIrq,
  output logic               irq,
  output logic               sysRst
);
  localparam int PCNT_W = (2 ** LEN_W) + 1;

  logic              ctrlWr, rangeWr, kick, ackWr;
  logic              enableRise, timeout, fire;
  logic              irqPend;
  logic [LEN_W-1:0]  lenSel;
  logic [PCNT_W-1:0] pulseCnt, pulseLoad;

  always_comb begin
    ctrlWr     = wrEn && (wrAddr == ADDR_CTRL);
    rangeWr    = wrEn && (wrAddr == ADDR_RANGE);
    ackWr      = wrEn && (wrAddr == ADDR_ACK);
    kick       = wrEn && (wrAddr == ADDR_KICK) && (wrData == KICK_KEY);
    enableRise = ctrlWr && wrData[0] && !enabled;
    timeout    = enabled && cntZero && !kick;
    fire       = timeout && (!modeIrq || (irqPend && !ackWr));
    pulseLoad  = PCNT_W'(1) << (32'(lenSel) + 1);
    stb.reload = kick || enableRise || timeout;
    stb.decr   = enabled && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b0;
      modeIrq  <= 1'b0;
      lenSel   <= '0;
      rangeSel <= '0;
    end else begin
      if (ctrlWr) begin
        enabled <= enabled | wrData[0];
        modeIrq <= wrData[1];
        lenSel  <= wrData[2 +: LEN_W];
      end
      if (rangeWr) rangeSel <= wrData[RANGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (kick)         irqPend <= 1'b0;
      else if (timeout) irqPend <= fire ? 1'b0 : 1'b1;
      else if (ackWr)   irqPend <= 1'b0;

      if (fire)                pulseCnt <= pulseLoad;
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - PCNT_W'(1);
    end
  end

  assign irq    = irqPend;
  assign sysRst = (pulseCnt != '0);
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16,
  parameter int RANGE_W  = 4,
  parameter int LEN_W    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       irq,
  output logic       sysRst
);
  cntStrobe_t         stb;
  logic [RANGE_W-1:0] rangeSel;
  logic               cntZero, enabled, modeIrq;

  wdog_ctrl #(.RANGE_W(RANGE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntZero(cntZero), .stb(stb), .rangeSel(rangeSel), .enabled(enabled),
    .modeIrq(modeIrq), .irq(irq), .sysRst(sysRst)
  );

  wdog_counter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .RANGE_W(RANGE_W)) u_cnt (
    .clk(clk), .rstN(rstN), .stb(stb), .rangeSel(rangeSel), .cntZero(cntZero)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [7:0] wrData,
  input logic       irq,
  input logic       sysRst,
  input logic       enabled,
  input logic       modeIrq,
  input logic       cntZero
);
  logic kickWr, ackWr;
  assign kickWr = wrEn && (wrAddr == ADDR_KICK) && (wrData == KICK_KEY);
  assign ackWr  = wrEn && (wrAddr == ADDR_ACK);

  // R8
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    enabled |=> enabled);

  // R5
  kick_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    kickWr |=> !irq);

  // R4
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !(enabled && cntZero)) |=> !irq);

  // R3
  irq_needs_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(modeIrq));

  // R3
  reset_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> !irq);

  // R9
  reset_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> $past(enabled));

  // R2
  direct_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && cntZero && !modeIrq && !kickWr) |=> sysRst);
endmodule

bind wdog_twostage wdog_twostage_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irq(irq), .sysRst(sysRst), .enabled(enabled), .modeIrq(modeIrq),
  .cntZero(cntZero)
);

// File: tb/tb_wdog_twostage.sv
`timescale 1ns/1ps
module tb_wdog_twostage;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       irq, sysRst;

  wdog_twostage #(.BASE_EXP(BASE)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irq(irq), .sysRst(sysRst)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string curReq = "R9";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  longint mCnt = 0;
  int mEn = 0, mMode = 0, mLen = 0, mRange = 0, mIrq = 0, mPulse = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mEn = 0; mMode = 0; mLen = 0; mRange = 0; mIrq = 0; mPulse = 0;
    end else begin
      bit isKick, isAck, isCtrl, isRange, rise, tmo, resetNow;
      longint preset;
      isKick  = wrEn && wrAddr == 2 && wrData == 8'h76;
      isAck   = wrEn && wrAddr == 3;
      isCtrl  = wrEn && wrAddr == 0;
      isRange = wrEn && wrAddr == 1;
      rise    = isCtrl && wrData[0] && mEn == 0;
      preset  = (longint'(1) << (BASE + mRange)) - 1;
      tmo     = mEn != 0 && mCnt == 0 && !isKick;
      resetNow = tmo && (mMode == 0 || (mIrq != 0 && !isAck));
      if (isKick) mIrq = 0;
      else if (tmo) mIrq = resetNow ? 0 : 1;
      else if (isAck) mIrq = 0;
      if (resetNow) mPulse = 2 << mLen;
      else if (mPulse > 0) mPulse--;
      if (isKick || rise || tmo) mCnt = preset;
      else if (mEn != 0) mCnt--;
      if (isCtrl) begin
        if (wrData[0]) mEn = 1;
        mMode = wrData[1];
        mLen  = wrData[4:2];
      end
      if (isRange) mRange = wrData[3:0];
    end
  end

  // per-cycle comparison and pulse monitors
  int runLen = 0, lastWidth = 0, pulseCount = 0;
  always @(negedge clk) begin
    if (rstN) begin
      check(irq == mIrq, curReq, "irq vs model", irq, mIrq);
      check(sysRst == (mPulse > 0), curReq, "sysRst vs model", sysRst, mPulse > 0);
      if (sysRst) begin
        if (runLen == 0) pulseCount++;
        runLen++;
      end else if (runLen != 0) begin
        lastWidth = runLen;
        runLen = 0;
      end
    end else runLen = 0;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic waitFor(input bit wantRst, input int maxN, output bit got);
    got = 0;
    for (int k = 0; k < maxN; k++) begin
      @(negedge clk);
      if ((wantRst ? sysRst : irq) == 1'b1) begin got = 1; break; end
    end
  endtask

  task automatic waitFall(input int maxN);
    for (int k = 0; k < maxN; k++) begin
      @(negedge clk);
      if (!sysRst) break;
    end
    idle(1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    bit got;
    int pc;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R9: reset state and no timeout while disabled
    curReq = "R9";
    check(irq == 0, "R9", "irq after reset", irq, 0);
    check(sysRst == 0, "R9", "sysRst after reset", sysRst, 0);
    wr(2'd2, 8'h76);
    idle(60);
    check(pulseCount == 0, "R9", "pulses while disabled", pulseCount, 0);
    check(irq == 0, "R9", "irq while disabled", irq, 0);

    // R1, R2: direct mode, range 0 (16 clocks), pulse length 2
    curReq = "R2";
    wr(2'd0, 8'h01);
    idle(15);
    check(sysRst == 0, "R1", "no reset before period", sysRst, 0);
    idle(1);
    check(sysRst == 1, "R2", "reset at period end", sysRst, 1);
    idle(4);
    check(lastWidth == 2, "R7", "pulse width L=0", lastWidth, 2);

    // R8: clearing enable bit has no effect
    curReq = "R8";
    wr(2'd0, 8'h00);
    pc = pulseCount;
    idle(64);
    check(pulseCount - pc >= 3, "R8", "pulses after enable=0 write", pulseCount - pc, 4);

    // R3, R4: interrupt-first mode, range 1 (32 clocks), pulse length 8
    doReset();
    curReq = "R3";
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0B);
    idle(31);
    check(irq == 0, "R1", "irq before 32 clocks", irq, 0);
    idle(1);
    check(irq == 1, "R3", "irq at first timeout", irq, 1);
    check(sysRst == 0, "R3", "no reset at first timeout", sysRst, 0);
    curReq = "R4";
    wr(2'd3, 8'h00);
    check(irq == 0, "R4", "irq after acknowledge", irq, 0);
    waitFor(0, 40, got);
    check(got, "R4", "irq raised again after ack", got, 1);
    check(sysRst == 0, "R4", "no reset after acknowledged stage", sysRst, 0);
    curReq = "R3";
    waitFor(1, 40, got);
    check(got, "R3", "reset on second timeout", got, 1);
    check(irq == 0, "R3", "irq cleared with reset", irq, 0);
    waitFall(20);
    check(lastWidth == 8, "R7", "pulse width L=2", lastWidth, 8);

    // R5: restart keeps timeouts away
    curReq = "R5";
    wr(2'd0, 8'h03);
    pc = pulseCount;
    wr(2'd3, 8'h00);
    for (int k = 0; k < 20; k++) begin
      wr(2'd2, 8'h76);
      idle(8);
    end
    check(pulseCount == pc, "R5", "no reset while restarted", pulseCount - pc, 0);
    check(irq == 0, "R5", "no irq while restarted", irq, 0);

    // R6: wrong keys do not restart
    curReq = "R6";
    wr(2'd2, 8'h76);
    wr(2'd2, 8'h75);
    wr(2'd2, 8'hFF);
    wr(2'd2, 8'h00);
    waitFor(0, 40, got);
    check(got, "R6", "irq despite wrong keys", got, 1);

    // R10: range change applies at the next load
    curReq = "R10";
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h76);
    check(irq == 0, "R5", "restart clears irq", irq, 0);
    idle(15);
    check(irq == 0, "R10", "no irq before new 16-clock period", irq, 0);
    idle(1);
    check(irq == 1, "R10", "irq at new 16-clock period", irq, 1);

    // R7: longest pulse, direct mode, range 5 (512 clocks)
    curReq = "R7";
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h1D);
    wr(2'd2, 8'h76);
    waitFor(1, 600, got);
    check(got, "R7", "reset with L=7", got, 1);
    waitFall(300);
    check(lastWidth == 256, "R7", "pulse width L=7", lastWidth, 256);

    idle(5);
    finishRun();
  end
endmodule